// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the bus interface of a small processor whose external bus shares eight pins between the low address byte and data, and whose 20-bit address shares its top four pins with status bits. A single request carries everything needed for one transfer: read or write, memory or I/O space, the 20-bit address, the write byte, a two-bit segment code and the current interrupt-enable flag. The block then steps through the clock states T1, T2, T3, any number of wait states Tw, and T4, and drives the address latch strobe, the space select, the read and write strobes, the transfer-direction line and the transceiver enable.

Wait states come from an external READY input. READY is sampled on the clock edge that ends T3 and on the edge that ends each Tw. A low sample adds another Tw and a high sample moves the cycle on to T4. For a read, the byte on the shared pins is captured on the edge that enters T4. It is then presented with a one-cycle done pulse that lasts for T4. A new request is taken only while the block is idle.

Top module: `bus_cycle_seq`

## Requirements
- R1: `req_ready` is high only in the idle state. A request presented with `req_valid` high while `req_ready` is high starts T1 on the next cycle. `req_valid` is ignored while a cycle is in progress.
- R2: `ale` is high for exactly one cycle (T1) per bus cycle and low at all other times.
- R3: In T1 `ad_out` carries address bits 7:0 with `ad_oe` high. `a_mid` carries address bits 15:8 from T1 through T4.
- R4: In T1 `a_hi` carries address bits 19:16 for a memory cycle and 4'b0000 for an I/O cycle.
- R5: From T2 through T4 `a_hi` carries status {bit3 = 0, bit2 = interrupt-enable flag, bits1:0 = segment code (00 ES, 01 SS, 10 CS, 11 DS)}.
- R6: `io_m`/`wr_n`/`rd_n` during the strobe phase (T2, T3, Tw) are 0/1/0 for a memory read, 0/0/1 for a memory write, 1/1/0 for an I/O read and 1/0/1 for an I/O write. Both strobes are high in T1, T4 and idle, and they are never low together.
- R7: READY is sampled at the end of T3 and of every Tw. Each low sample inserts one more Tw. The done pulse appears exactly 3 + N cycles after the ALE cycle, where N is the number of low samples.
- R8: `dt_r` equals 1 for a write and 0 for a read from T1 to the end of T4. `den_n` is low from T2 through T4 and high in T1 and idle.
- R9: During T2 through T4 of a read, `ad_oe` is low. The value on `ad_in` at the end of the last T3/Tw appears on `rdata` while `done` is high.
- R10: During T2 through T4 of a write, `ad_oe` is high and `ad_out` carries the write byte.
- R11: `done` is high for exactly the T4 cycle, and the block is idle (`req_ready` high) on the following cycle.
- R12: While `rst_n` is low the block is idle, with `ale` low, `rd_n`, `wr_n` and `den_n` high, `ad_oe` low and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 8 | Write byte |
| req_seg | input | 2 | Segment code for status |
| int_en | input | 1 | Interrupt-enable flag for status |
| ad_out | output | 8 | Shared address/data pins, outgoing value |
| ad_oe | output | 1 | Output enable of the shared pins |
| ad_in | input | 8 | Shared pins, incoming value |
| a_mid | output | 8 | Address bits 15:8 |
| a_hi | output | 4 | Address bits 19:16 in T1, status afterwards |
| ale | output | 1 | Address latch strobe, high in T1 |
| io_m | output | 1 | 1 = I/O, 0 = memory |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| dt_r | output | 1 | Transfer direction, 1 = outgoing |
| den_n | output | 1 | Data transceiver enable, active low |
| ready | input | 1 | Device ready, low inserts wait states |
| rdata | output | 8 | Captured read byte |
| done | output | 1 | One-cycle completion pulse in T4 |

## Verification
A wrong state register shows at the pins at once. An ALE that lasts two cycles, a strobe held into T4, a missing status on the upper pins or a premature enable of the shared pins all appear within the same clock state in which the error occurs. A miscount of wait states does not appear until the done pulse, which arrives one or more cycles off the expected 3 + N spacing from ALE. A missed read capture is seen only as a wrong `rdata` byte in T4. For that reason every cycle type is run with zero, one and three wait states, and every pin is compared in every state.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5
  } bus_state_e;
endpackage

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import bus_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       ready,
  output bus_state_e state
);
  bus_state_e state_nxt;

  always_comb begin
    state_nxt = state;
    case (state)
      ST_IDLE: if (start) state_nxt = ST_T1;
      ST_T1:   state_nxt = ST_T2;
      ST_T2:   state_nxt = ST_T3;
      ST_T3,
      ST_TW:   state_nxt = ready ? ST_T4 : ST_TW;
      ST_T4:   state_nxt = ST_IDLE;
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nxt;
  end
endmodule

// File: rtl/bus_req_hold.sv
module bus_req_hold #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  parameter int SEG_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              cap_en,
  input  logic              req_write,
  input  logic              req_io,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic              int_en,
  input  logic [DATA_W-1:0] ad_in,
  output logic              h_write,
  output logic              h_io,
  output logic [ADDR_W-1:0] h_addr,
  output logic [DATA_W-1:0] h_wdata,
  output logic [SEG_W-1:0]  h_seg,
  output logic              h_ie,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_write <= 1'b0;
      h_io    <= 1'b0;
      h_addr  <= '0;
      h_wdata <= '0;
      h_seg   <= '0;
      h_ie    <= 1'b0;
    end else if (load_en) begin
      h_write <= req_write;
      h_io    <= req_io;
      h_addr  <= req_addr;
      h_wdata <= req_wdata;
      h_seg   <= req_seg;
      h_ie    <= int_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (cap_en) rdata <= ad_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= cap_en;
  end
endmodule

// File: rtl/bus_pin_mux.sv
module bus_pin_mux
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int IO_W   = 16,
  parameter int DATA_W = 8,
  parameter int SEG_W  = 2
) (
  input  bus_state_e               state,
  input  logic                     h_write,
  input  logic                     h_io,
  input  logic [ADDR_W-1:0]        h_addr,
  input  logic [DATA_W-1:0]        h_wdata,
  input  logic [SEG_W-1:0]         h_seg,
  input  logic                     h_ie,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic [IO_W-DATA_W-1:0]   a_mid,
  output logic [ADDR_W-IO_W-1:0]   a_hi,
  output logic                     ale,
  output logic                     io_m,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     dt_r,
  output logic                     den_n
);
  localparam int HI_W = ADDR_W - IO_W;

  logic [HI_W-1:0] status;
  assign status = HI_W'({1'b0, h_ie, h_seg});

  always_comb begin
    ad_out = '0;
    ad_oe  = 1'b0;
    a_mid  = '0;
    a_hi   = '0;
    ale    = 1'b0;
    io_m   = 1'b0;
    rd_n   = 1'b1;
    wr_n   = 1'b1;
    dt_r   = 1'b1;
    den_n  = 1'b1;
    if (state != ST_IDLE) begin
      a_mid = h_addr[IO_W-1:DATA_W];
      io_m  = h_io;
      dt_r  = h_write;
    end
    case (state)
      ST_T1: begin
        ale    = 1'b1;
        ad_out = h_addr[DATA_W-1:0];
        ad_oe  = 1'b1;
        a_hi   = h_io ? '0 : h_addr[ADDR_W-1:IO_W];
      end
      ST_T2, ST_T3, ST_TW, ST_T4: begin
        a_hi  = status;
        den_n = 1'b0;
        if (h_write) begin
          ad_out = h_wdata;
          ad_oe  = 1'b1;
        end
        if (state != ST_T4) begin
          rd_n = h_write;
          wr_n = !h_write;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int IO_W   = 16,
  parameter int DATA_W = 8,
  parameter int SEG_W  = 2,
  localparam int MID_W = IO_W - DATA_W,
  localparam int HI_W  = ADDR_W - IO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_io,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic              int_en,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic [MID_W-1:0]  a_mid,
  output logic [HI_W-1:0]   a_hi,
  output logic              ale,
  output logic              io_m,
  output logic              rd_n,
  output logic              wr_n,
  output logic              dt_r,
  output logic              den_n,
  input  logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);
  bus_state_e        state;
  logic              start;
  logic              capture;
  logic              h_write;
  logic              h_io;
  logic [ADDR_W-1:0] h_addr;
  logic [DATA_W-1:0] h_wdata;
  logic [SEG_W-1:0]  h_seg;
  logic              h_ie;

  assign req_ready = (state == ST_IDLE);
  assign start     = req_valid && req_ready;
  assign capture   = ((state == ST_T3) || (state == ST_TW)) && ready;

  bus_seq_fsm i_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .ready (ready),
    .state (state)
  );

  bus_req_hold #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SEG_W  (SEG_W)
  ) i_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (start),
    .cap_en    (capture),
    .req_write (req_write),
    .req_io    (req_io),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_seg   (req_seg),
    .int_en    (int_en),
    .ad_in     (ad_in),
    .h_write   (h_write),
    .h_io      (h_io),
    .h_addr    (h_addr),
    .h_wdata   (h_wdata),
    .h_seg     (h_seg),
    .h_ie      (h_ie),
    .rdata     (rdata),
    .done      (done)
  );

  bus_pin_mux #(
    .ADDR_W (ADDR_W),
    .IO_W   (IO_W),
    .DATA_W (DATA_W),
    .SEG_W  (SEG_W)
  ) i_pins (
    .state   (state),
    .h_write (h_write),
    .h_io    (h_io),
    .h_addr  (h_addr),
    .h_wdata (h_wdata),
    .h_seg   (h_seg),
    .h_ie    (h_ie),
    .ad_out  (ad_out),
    .ad_oe   (ad_oe),
    .a_mid   (a_mid),
    .a_hi    (a_hi),
    .ale     (ale),
    .io_m    (io_m),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .dt_r    (dt_r),
    .den_n   (den_n)
  );
endmodule

// File: rtl/bus_cycle_seq_chk.sv
module bus_cycle_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic dt_r,
  input logic den_n,
  input logic ad_oe,
  input logic ready,
  input logic done
);
  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ale);

  p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  p_no_dual_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  p_done_after_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) && !ready |=> !done);

  p_den_not_in_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !den_n |-> !ale);

  p_dir_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !ale && !den_n) |-> $stable(dt_r));

  p_read_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  p_done_to_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (req_ready && !done));
endmodule

bind bus_cycle_seq bus_cycle_seq_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .ale       (ale),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .dt_r      (dt_r),
  .den_n     (den_n),
  .ad_oe     (ad_oe),
  .ready     (ready),
  .done      (done)
);

// File: tb/test_bus_cycle_seq.sv
module test_bus_cycle_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write, req_io, int_en;
  logic [19:0] req_addr;
  logic [7:0]  req_wdata;
  logic [1:0]  req_seg;
  logic [7:0]  ad_out, ad_in, a_mid, rdata;
  logic [3:0]  a_hi;
  logic        ad_oe, ale, io_m, rd_n, wr_n, dt_r, den_n, ready, done;

  int n_chk = 0;
  int n_fail = 0;
  int cyc_cnt = 0;
  bit finished = 0;

  typedef struct {
    bit         wr;
    int         nw;
    logic [7:0] rv;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  bus_cycle_seq i_bus_cycle_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_io(req_io), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_seg(req_seg), .int_en(int_en),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .a_mid(a_mid),
    .a_hi(a_hi), .ale(ale), .io_m(io_m), .rd_n(rd_n), .wr_n(wr_n),
    .dt_r(dt_r), .den_n(den_n), .ready(ready), .rdata(rdata), .done(done)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // scoreboard monitor: cycle spacing from ALE to done, and read data
  always @(negedge clk) begin
    if (ale) cyc_cnt = 0;
    else     cyc_cnt++;
    if (done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11 unexpected done", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(cyc_cnt == 3 + e.nw, "R7 done spacing", cyc_cnt, 3 + e.nw);
        if (!e.wr) chk(rdata == e.rv, "R9 read data", rdata, e.rv);
      end
    end
  end

  task automatic chk_data_phase(input bit wr, input bit ie, input logic [1:0] sg,
                                input logic [7:0] wd, input logic [7:0] a_m,
                                input bit strobe);
    chk(ale == 1'b0, "R2 ale low", ale, 0);
    chk(a_hi == {1'b0, ie, sg}, "R5 status", a_hi, {1'b0, ie, sg});
    chk(a_mid == a_m, "R3 mid address", a_mid, a_m);
    chk(den_n == 1'b0, "R8 den active", den_n, 0);
    chk(dt_r == wr, "R8 direction", dt_r, wr);
    chk(req_ready == 1'b0, "R1 busy", req_ready, 0);
    if (strobe) begin
      chk(rd_n == wr, "R6 rd strobe", rd_n, wr);
      chk(wr_n == !wr, "R6 wr strobe", wr_n, !wr);
    end else begin
      chk(rd_n && wr_n, "R6 strobes idle in T4", {rd_n, wr_n}, 2'b11);
    end
    if (wr) begin
      chk(ad_oe == 1'b1, "R10 oe", ad_oe, 1);
      chk(ad_out == wd, "R10 write data", ad_out, wd);
    end else begin
      chk(ad_oe == 1'b0, "R9 released", ad_oe, 0);
    end
  endtask

  task automatic run_cyc(input bit wr, input bit io, input logic [19:0] a,
                         input logic [7:0] wd, input logic [1:0] sg, input bit ie,
                         input int nw, input logic [7:0] rv);
    exp_q.push_back('{wr, nw, rv});
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_io = io; req_addr = a;
    req_wdata = wd; req_seg = sg; int_en = ie; ready = 1'b1; ad_in = 8'h5A;
    @(negedge clk); // T1
    req_valid = 1'b1; req_addr = ~a; // R1: ignored while busy
    chk(req_ready == 1'b0, "R1 busy in T1", req_ready, 0);
    chk(ale == 1'b1, "R2 ale in T1", ale, 1);
    chk(ad_out == a[7:0] && ad_oe, "R3 low address", ad_out, a[7:0]);
    chk(a_mid == a[15:8], "R3 mid address", a_mid, a[15:8]);
    chk(a_hi == (io ? 4'h0 : a[19:16]), "R4 upper address", a_hi, io ? 4'h0 : a[19:16]);
    chk(io_m == io, "R6 io_m", io_m, io);
    chk(rd_n && wr_n, "R6 no strobe in T1", {rd_n, wr_n}, 2'b11);
    chk(dt_r == wr, "R8 direction in T1", dt_r, wr);
    chk(den_n == 1'b1, "R8 den off in T1", den_n, 1);
    @(negedge clk); // T2
    req_valid = 1'b0;
    if (!wr) ad_in = rv;
    chk(io_m == io, "R6 io_m held", io_m, io);
    chk_data_phase(wr, ie, sg, wd, a[15:8], 1'b1);
    ready = (nw == 0);
    @(negedge clk); // T3
    chk_data_phase(wr, ie, sg, wd, a[15:8], 1'b1);
    chk(done == 1'b0, "R7 no done in T3", done, 0);
    for (int k = 1; k <= nw; k++) begin
      @(negedge clk); // Tw
      chk_data_phase(wr, ie, sg, wd, a[15:8], 1'b1);
      chk(done == 1'b0, "R7 no done in Tw", done, 0);
      ready = (k == nw);
    end
    @(negedge clk); // T4
    if (!wr) ad_in = ~rv;
    ready = 1'b1;
    chk(done == 1'b1, "R11 done in T4", done, 1);
    chk_data_phase(wr, ie, sg, wd, a[15:8], 1'b0);
    @(negedge clk); // idle
    chk(req_ready == 1'b1, "R11 idle after T4", req_ready, 1);
    chk(done == 1'b0, "R11 done single", done, 0);
    chk(ale == 1'b0 && den_n == 1'b1, "R1 no restart", {ale, den_n}, 2'b01);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_io = 1'b0;
    req_addr = '0; req_wdata = '0; req_seg = '0; int_en = 1'b0;
    ad_in = '0; ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R12 idle", req_ready, 1);
    chk(ale == 1'b0 && ad_oe == 1'b0 && done == 1'b0, "R12 outputs low",
        {ale, ad_oe, done}, 0);
    chk(rd_n && wr_n && den_n, "R12 strobes high", {rd_n, wr_n, den_n}, 3'b111);
    rst_n = 1'b1;
    for (int w = 0; w < 3; w++) begin
      int nw;
      nw = (w == 2) ? 3 : w;
      run_cyc(0, 0, 20'hA5C3E + 20'(w), 8'h00, 2'b10, 1, nw, 8'h3C + 8'(w));
      run_cyc(1, 0, 20'h7F012 + 20'(w), 8'hC7 ^ 8'(w), 2'b11, 0, nw, 8'h00);
      run_cyc(0, 1, 20'hF1234 + 20'(w), 8'h00, 2'b01, 0, nw, 8'h96 ^ 8'(w));
      run_cyc(1, 1, 20'h9ABCD + 20'(w), 8'h5E + 8'(w), 2'b00, 1, nw, 8'h00);
    end
    chk(exp_q.size() == 0, "R11 all cycles completed", exp_q.size(), 0);
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule